// File: doc/BRIEF.md
# Tamper Pin Detection Controller

This block watches an external tamper input. When the pin reaches the active level that software has programmed, it erases a bank of backup data registers and raises status and interrupt flags. The pin is first passed through a synchronizer. It is then compared against a programmable polarity, but only while detection is enabled. On the rising edge of that qualified condition, the block issues a one-cycle clear-all strobe to the backup register bank.

Software reaches the block through two 16-bit registers, selected by a one-bit address. The control register, at address 0, holds the detection enable and the polarity. The status register, at address 1, holds the interrupt enable, two write-one-to-clear command bits, and two read-only flags: one for events and one for interrupts.

There are two resets. The system reset clears all state. The backup-domain reset clears only the control register and leaves the flags and the interrupt enable untouched. The enable and the polarity update in the same clock edge, so clearing both in one write cannot produce a false event.

Top module: `tamper_guard`

## Requirements
- R1: After system reset, both registers read 0x0000, and `irq` and `erase_pulse` are low.
- R2: The control register keeps the detection enable at bit 0 and the polarity at bit 1. Every other bit reads 0.
- R3: The qualified condition is true when the enable is 1 and the pin meets the polarity. With polarity 0 the pin must be high; with polarity 1 it must be low. While the enable is 0, the pin has no effect.
- R4: After a pin change, the erase strobe and the event flag respond at the third rising clock edge: two synchronizer stages plus one register.
- R5: `erase_pulse` is high for exactly one cycle when the qualified condition rises. It does not repeat while the condition is held.
- R6: The event flag sits at status bit 8. It sets whenever the condition is true and holds afterwards. Writing 1 to status bit 0 clears it, but only in a cycle where the condition is absent.
- R7: The interrupt flag sits at status bit 9, and the interrupt enable at status bit 2. The interrupt flag sets when the condition is true while the interrupt enable is 1, and `irq` follows the interrupt flag.
- R8: Writing 1 to status bit 1 clears the interrupt flag unless the condition is present in that cycle. Writing 0 to the interrupt enable also clears the interrupt flag.
- R9: Status bits 0 and 1 are command bits and always read 0. All status bits other than 2, 8 and 9 read 0.
- R10: A single write that clears both the enable and the polarity produces no event. A polarity change while enabled is evaluated like any other level change.
- R11: The backup-domain reset clears the control register only. The event flag, the interrupt flag and the interrupt enable keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Asynchronous system reset, active low, clears all state |
| bkp_rst_n | input | 1 | Synchronous backup-domain reset, active low, clears the control register only |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 selects control, 1 selects status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| tamper_pin | input | 1 | Asynchronous tamper input |
| erase_pulse | output | 1 | One-cycle clear-all strobe to the backup register bank |
| irq | output | 1 | Interrupt line, equal to the interrupt flag |

## Verification
The assertions check several properties on every cycle:
- the erase strobe never lasts two cycles;
- the erase strobe always coincides with a set event flag;
- the erase strobe never follows a disabled cycle;
- the interrupt line is never high without the interrupt enable;
- a clear command issued during an active condition never drops a flag;
- a backup-domain reset keeps a pending interrupt.

Only the bench's scenarios can show the rest. Those cover the exact three-edge latency, the polarity truth table over every combination of enable, polarity, pin and interrupt enable, and the absence of an event when enable and polarity are cleared together. They also cover the read-back layout of both registers.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
    localparam int unsigned TG_DATA_W   = 16;
    localparam int unsigned CTL_EN_BIT  = 0;
    localparam int unsigned CTL_LVL_BIT = 1;
    localparam int unsigned STS_CEV_BIT = 0;
    localparam int unsigned STS_CIR_BIT = 1;
    localparam int unsigned STS_IE_BIT  = 2;
    localparam int unsigned STS_EVF_BIT = 8;
    localparam int unsigned STS_IRF_BIT = 9;
    localparam logic        ADDR_CTL    = 1'b0;
    localparam logic        ADDR_STS    = 1'b1;

    typedef struct packed {
        logic en;
        logic lvl;
        logic ie;
        logic evf;
        logic irf;
    } tg_state_t;
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < int'(STAGES); i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/tamper_detect.sv
module tamper_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic en,
    input  logic lvl,
    output logic cond,
    output logic erase
);
    typedef struct packed {
        logic cond;
        logic erase;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        // active high when lvl=0, active low when lvl=1
        cond        = en & (pin_s ^ lvl);
        det_d.cond  = cond;
        det_d.erase = cond & ~det_q.cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign erase = det_q.erase;
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
    import tamper_pkg::*;
#(
    parameter int unsigned DATA_W      = TG_DATA_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              sys_rst_n,
    input  logic              bkp_rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tamper_pin,
    output logic              erase_pulse,
    output logic              irq
);
    tg_state_t state_d, state_q;
    logic      pin_s;
    logic      cond;
    logic      ctl_wr, sts_wr, clr_ev, clr_ir;

    tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .async_in (tamper_pin),
        .sync_out (pin_s)
    );

    tamper_detect u_det (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .pin_s (pin_s),
        .en    (state_q.en),
        .lvl   (state_q.lvl),
        .cond  (cond),
        .erase (erase_pulse)
    );

    always_comb begin
        ctl_wr  = reg_wr & (reg_addr == ADDR_CTL);
        sts_wr  = reg_wr & (reg_addr == ADDR_STS);
        clr_ev  = sts_wr & reg_wdata[STS_CEV_BIT];
        clr_ir  = sts_wr & reg_wdata[STS_CIR_BIT];
        state_d = state_q;
        if (ctl_wr) begin
            state_d.en  = reg_wdata[CTL_EN_BIT];
            state_d.lvl = reg_wdata[CTL_LVL_BIT];
        end
        if (!bkp_rst_n) begin
            state_d.en  = 1'b0;
            state_d.lvl = 1'b0;
        end
        if (sts_wr) state_d.ie = reg_wdata[STS_IE_BIT];
        state_d.evf = cond | (state_q.evf & ~clr_ev);
        state_d.irf = state_d.ie & (cond | (state_q.irf & ~clr_ir));
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) state_q <= '0;
        else            state_q <= state_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTL) begin
            reg_rdata[CTL_EN_BIT]  = state_q.en;
            reg_rdata[CTL_LVL_BIT] = state_q.lvl;
        end else begin
            reg_rdata[STS_IE_BIT]  = state_q.ie;
            reg_rdata[STS_EVF_BIT] = state_q.evf;
            reg_rdata[STS_IRF_BIT] = state_q.irf;
        end
    end

    assign irq = state_q.irf;
endmodule

// File: rtl/tamper_guard_chk.sv
module tamper_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic bkp_rst_n,
    input logic reg_wr,
    input logic reg_addr,
    input logic cev_bit,
    input logic cir_bit,
    input logic ie_bit,
    input logic cond,
    input logic en,
    input logic ie,
    input logic evf,
    input logic erase,
    input logic irq
);
    assert_erase_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> !erase);

    assert_erase_flags_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase |-> evf);

    assert_erase_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        erase |-> $past(en));

    assert_irq_needs_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie);

    assert_clear_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && cev_bit && cond) |=> evf);

    assert_irq_clear_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && cir_bit && ie_bit && cond) |=> irq);

    assert_bkp_keeps_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bkp_rst_n && irq && !reg_wr) |=> irq);
endmodule

bind tamper_guard tamper_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .bkp_rst_n (bkp_rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .cev_bit   (reg_wdata[0]),
    .cir_bit   (reg_wdata[1]),
    .ie_bit    (reg_wdata[2]),
    .cond      (cond),
    .en        (state_q.en),
    .ie        (state_q.ie),
    .evf       (state_q.evf),
    .erase     (erase_pulse),
    .irq       (irq)
);

// File: tb/tamper_guard_tb.sv
module tamper_guard_tb;
    logic        clk = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        bkp_rst_n = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tamper_pin = 1'b0;
    logic        erase_pulse;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int erase_cnt = 0;
    logic [15:0] v;

    always #2 clk = ~clk;

    tamper_guard u_dut (
        .clk         (clk),
        .sys_rst_n   (sys_rst_n),
        .bkp_rst_n   (bkp_rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .tamper_pin  (tamper_pin),
        .erase_pulse (erase_pulse),
        .irq         (irq)
    );

    always @(negedge clk) if (erase_pulse) erase_cnt++;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        sys_rst_n = 1'b0;
        cyc(2);
        sys_rst_n = 1'b1;
        cyc(3);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        rd(1'b0, v); check("R1 ctl", v, 16'h0000);
        rd(1'b1, v); check("R1 sts", v, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 erase", {15'd0, erase_pulse}, 16'd0);

        // R2 / R9 layout, pin low so no event with polarity 0
        wr(1'b0, 16'hFFFC); rd(1'b0, v); check("R2 ctl upper bits", v, 16'h0000);
        wr(1'b1, 16'hFFFF); rd(1'b1, v); check("R9 sts layout", v, 16'h0004);
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'hFFFF); rd(1'b0, v); check("R2 ctl bits", v, 16'h0003);

        // R3/R5/R6/R7 exhaustive sweep of en, lvl, pin, ie
        for (int k = 0; k < 16; k++) begin
            logic en_b, lvl_b, pin_b, ie_b, hit;
            en_b = k[0]; lvl_b = k[1]; pin_b = k[2]; ie_b = k[3];
            hit = en_b & (pin_b ^ lvl_b);
            tamper_pin = pin_b;
            do_reset();
            wr(1'b1, {13'd0, ie_b, 2'b00});
            erase_cnt = 0;
            wr(1'b0, {14'd0, lvl_b, en_b});
            cyc(3);
            rd(1'b1, v);
            check("R3 sweep event flag", {15'd0, v[8]}, {15'd0, hit});
            check("R7 sweep irq", {15'd0, irq}, {15'd0, hit & ie_b});
            check("R5 sweep erase count", erase_cnt[15:0], {15'd0, hit});
        end

        // R4 latency and R5 single pulse
        tamper_pin = 1'b0;
        do_reset();
        wr(1'b1, 16'h0004);
        wr(1'b0, 16'h0001);
        cyc(2);
        erase_cnt = 0;
        tamper_pin = 1'b1;
        cyc(2);
        check("R4 no erase after 2 edges", {15'd0, erase_pulse}, 16'd0);
        cyc(1);
        check("R4 erase at 3rd edge", {15'd0, erase_pulse}, 16'd1);
        rd(1'b1, v); check("R4 event at 3rd edge", {15'd0, v[8]}, 16'd1);
        cyc(1);
        check("R5 erase one cycle", {15'd0, erase_pulse}, 16'd0);
        cyc(4);
        check("R5 no repeat while held", erase_cnt[15:0], 16'd1);

        // R6 / R8 clears blocked while condition present
        wr(1'b1, 16'h0007);
        rd(1'b1, v); check("R6 clear blocked", {15'd0, v[8]}, 16'd1);
        check("R8 clear blocked", {15'd0, irq}, 16'd1);
        tamper_pin = 1'b0;
        cyc(4);
        rd(1'b1, v); check("R6 flag holds after pin drop", {15'd0, v[8]}, 16'd1);
        wr(1'b1, 16'h0005);
        rd(1'b1, v); check("R6 event cleared", {15'd0, v[8]}, 16'd0);
        check("R8 irq kept without command", {15'd0, irq}, 16'd1);
        wr(1'b1, 16'h0006);
        check("R8 irq cleared by command", {15'd0, irq}, 16'd0);
        tamper_pin = 1'b1; cyc(4);
        check("R7 irq set again", {15'd0, irq}, 16'd1);
        tamper_pin = 1'b0; cyc(4);
        wr(1'b1, 16'h0000);
        check("R8 irq cleared by ie=0", {15'd0, irq}, 16'd0);

        // R11 backup-domain reset
        wr(1'b1, 16'h0004);
        tamper_pin = 1'b1; cyc(4);
        tamper_pin = 1'b0; cyc(4);
        @(negedge clk); bkp_rst_n = 1'b0;
        @(negedge clk); bkp_rst_n = 1'b1;
        rd(1'b0, v); check("R11 ctl cleared", v, 16'h0000);
        rd(1'b1, v); check("R11 status kept", v, 16'h0304);
        check("R11 irq kept", {15'd0, irq}, 16'd1);

        // R10 simultaneous clear gives no event, polarity change re-evaluated
        tamper_pin = 1'b1;
        do_reset();
        wr(1'b0, 16'h0003);
        cyc(4);
        erase_cnt = 0;
        wr(1'b0, 16'h0000);
        cyc(5);
        check("R10 no spurious erase", erase_cnt[15:0], 16'd0);
        rd(1'b1, v); check("R10 no spurious event", v, 16'h0000);
        wr(1'b0, 16'h0003);
        cyc(2);
        erase_cnt = 0;
        wr(1'b0, 16'h0001);
        cyc(2);
        rd(1'b1, v); check("R10 polarity change event", {15'd0, v[8]}, 16'd1);
        check("R10 polarity change erase", erase_cnt[15:0], 16'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule